// File: doc/BRIEF.md
# Receive DMA Overrun Responder

This block sits in the receive side of a USB controller's transaction engine and decides what happens when the data path into system memory cannot keep up. It distinguishes two overrun causes. A memory-latency overrun is reported by the DMA path on the `lat_ovr` input. An oversized packet is detected internally: a byte counter, restarted at every token, compares the received bytes against the endpoint's MaxPacket.

Each received byte is offered on `rx_byte_vld`. The block grants the memory write (`mem_wr_en`) only while the stored count is below MaxPacket, so a buffer never overflows. When the packet ends (`tok_end`), the block issues its verdict one cycle later. The verdict covers the handshake (ACK, NAK, or none, which lets the transaction time out) and whether the buffer descriptor is written back. A write-back carries a PID field and a length field. The verdict also updates two sticky write-1-to-clear status bits, DMA error and token done. These bits drive gated interrupt lines.

A latency overrun takes precedence over an oversized packet in the same token, because the data in memory is incomplete either way.

Top module: `usb_ovr_responder`

## Requirements
- R1: On a latency overrun in device mode on a non-isochronous transfer, `hs_ack`=0 and `hs_nak` pulses for one cycle, in the cycle after `tok_end`.
- R2: On a latency overrun in host mode, neither `hs_ack` nor `hs_nak` is raised, so the transaction ends in a bus timeout.
- R3: A non-isochronous token without latency overrun, whether oversized or not, gets an `hs_ack` pulse in the cycle after `tok_end` and never `hs_nak`. `hs_ack` and `hs_nak` are never high together.
- R4: Within a token, `mem_wr_en` is granted for exactly the first min(N, MaxPacket) of N received bytes. Later bytes are dropped.
- R5: Whenever `bd_wr` pulses, `bd_len` equals min(received bytes, MaxPacket). For an oversized packet this is MaxPacket.
- R6: A latency overrun or an oversized packet sets `dma_err_sts` in the cycle after `tok_end`, in host and device mode. A packet that is neither leaves it clear.
- R7: On a latency overrun in host mode, `bd_wr` pulses with `bd_pid`=4'b1111, and `tok_dne_sts` is set.
- R8: On a latency overrun in device mode, `bd_wr` stays low and `tok_dne_sts` stays clear.
- R9: Without a latency overrun, `bd_wr` pulses with `bd_pid` equal to the PID captured at `tok_start`, and `tok_dne_sts` is set.
- R10: `irq_dma_err` is high exactly when `dma_err_sts`, `err_en_dma` and `int_en_err` are all high. `irq_tok_done` is high exactly when `tok_dne_sts` and `int_en_tok` are both high.
- R11: When `clr_wr` is high, `clr_data` bit 0 clears `dma_err_sts` and bit 1 clears `tok_dne_sts`. A 0 bit leaves its status unchanged. A set event in the same cycle as a clear wins, and the bit stays 1.
- R12: An isochronous transfer never raises `hs_ack` or `hs_nak`, whatever the overrun cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_mode | input | 1 | 1 = host, 0 = device |
| iso_xfer | input | 1 | 1 = isochronous transfer |
| tok_start | input | 1 | Token start pulse; restarts the byte count and captures `tok_pid` |
| tok_pid | input | 4 | PID of the current token |
| tok_end | input | 1 | End-of-packet pulse; triggers the verdict |
| rx_byte_vld | input | 1 | One received byte offered to memory |
| lat_ovr | input | 1 | Memory-latency overrun event during the token |
| max_pkt | input | MPS_W | Endpoint MaxPacket in bytes |
| err_en_dma | input | 1 | Error enable for DMA error |
| int_en_err | input | 1 | Top-level interrupt enable for errors |
| int_en_tok | input | 1 | Interrupt enable for token done |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 2 | Write-1-to-clear mask: bit 0 DMA error, bit 1 token done |
| mem_wr_en | output | 1 | Byte may be written to memory |
| hs_ack | output | 1 | Send ACK (pulse) |
| hs_nak | output | 1 | Send NAK (pulse) |
| bd_wr | output | 1 | Descriptor write-back request (pulse) |
| bd_pid | output | 4 | PID field for the write-back |
| bd_len | output | MPS_W | Length field for the write-back |
| dma_err_sts | output | 1 | Sticky DMA error status |
| tok_dne_sts | output | 1 | Sticky token-done status |
| irq_dma_err | output | 1 | DMA error interrupt |
| irq_tok_done | output | 1 | Token-done interrupt |

## Verification
The bench builds the block with `MPS_W`=4, so MaxPacket spans 0 to 15. That keeps packets short enough to sweep every combination of mode, transfer type and latency overrun. The sweep uses MaxPacket values 0, 1, 7 and 15, with byte counts below, at, just above and well above each limit. This reaches the zero-length buffer, the exact-fit packet and the one-byte overflow, all within a few cycles per token. All eight combinations of the three enable inputs are applied against set status bits. A clear is also timed to land on the same edge as a new error.

// File: rtl/usb_ovr_pkg.sv
package usb_ovr_pkg;
  localparam logic [3:0] PID_LAT_ERR = 4'b1111;
  localparam int STS_DMA = 0;
  localparam int STS_TOK = 1;
  localparam int STS_W   = 2;

  typedef struct packed {
    logic       ack;
    logic       nak;
    logic       wb;
    logic [3:0] pid;
    logic       set_dma;
  } verdict_t;
endpackage

// File: rtl/usb_ovr_bytecnt.sv
module usb_ovr_bytecnt #(
  parameter int MPS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_start,
  input  logic             rx_byte_vld,
  input  logic [MPS_W-1:0] max_pkt,
  output logic             mem_wr_en,
  output logic             oversize,
  output logic [MPS_W-1:0] stored_len
);
  localparam int CNT_W = MPS_W + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] limit;

  assign limit      = {1'b0, max_pkt};
  assign mem_wr_en  = rx_byte_vld && (cnt_q < limit);
  assign oversize   = cnt_q > limit;
  assign stored_len = oversize ? max_pkt : cnt_q[MPS_W-1:0];

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (tok_start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (rx_byte_vld && (cnt_q != CNT_SAT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !tok_start) |=> (cnt_q <= limit)); // R4
endmodule

// File: rtl/usb_ovr_decide.sv
module usb_ovr_decide
  import usb_ovr_pkg::*;
(
  input  logic       host_mode,
  input  logic       iso_xfer,
  input  logic       lat_any,
  input  logic       oversize,
  input  logic [3:0] tok_pid,
  output verdict_t   vrd
);
  always_comb begin
    if (lat_any) begin
      vrd.ack     = 1'b0;
      vrd.nak     = !iso_xfer && !host_mode;
      vrd.wb      = host_mode;
      vrd.pid     = PID_LAT_ERR;
      vrd.set_dma = 1'b1;
    end else begin
      vrd.ack     = !iso_xfer;
      vrd.nak     = 1'b0;
      vrd.wb      = 1'b1;
      vrd.pid     = tok_pid;
      vrd.set_dma = oversize;
    end
  end
endmodule

// File: rtl/usb_ovr_status.sv
module usb_ovr_status
  import usb_ovr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_dma,
  input  logic             set_tok,
  input  logic             clr_wr,
  input  logic [STS_W-1:0] clr_data,
  input  logic             err_en_dma,
  input  logic             int_en_err,
  input  logic             int_en_tok,
  output logic             dma_err_sts,
  output logic             tok_dne_sts,
  output logic             irq_dma_err,
  output logic             irq_tok_done
);
  logic [STS_W-1:0] sts_q, sts_d, set_v, clr_v;
  logic             sts_en;

  assign set_v = {set_tok, set_dma};
  assign clr_v = clr_wr ? clr_data : '0;

  always_comb begin
    sts_en = clr_wr || (|set_v);
    sts_d  = (sts_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign dma_err_sts  = sts_q[STS_DMA];
  assign tok_dne_sts  = sts_q[STS_TOK];
  assign irq_dma_err  = dma_err_sts && err_en_dma && int_en_err;
  assign irq_tok_done = tok_dne_sts && int_en_tok;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_dma |=> dma_err_sts); // R11
  AST_CLR_TOK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[STS_TOK] && !set_tok) |=> !tok_dne_sts); // R11
endmodule

// File: rtl/usb_ovr_responder.sv
module usb_ovr_responder
  import usb_ovr_pkg::*;
#(
  parameter int MPS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             iso_xfer,
  input  logic             tok_start,
  input  logic [3:0]       tok_pid,
  input  logic             tok_end,
  input  logic             rx_byte_vld,
  input  logic             lat_ovr,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             err_en_dma,
  input  logic             int_en_err,
  input  logic             int_en_tok,
  input  logic             clr_wr,
  input  logic [1:0]       clr_data,
  output logic             mem_wr_en,
  output logic             hs_ack,
  output logic             hs_nak,
  output logic             bd_wr,
  output logic [3:0]       bd_pid,
  output logic [MPS_W-1:0] bd_len,
  output logic             dma_err_sts,
  output logic             tok_dne_sts,
  output logic             irq_dma_err,
  output logic             irq_tok_done
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             lat_q, lat_d, lat_any;
  logic [3:0]       pid_q;
  logic             oversize;
  logic [MPS_W-1:0] stored_len;
  verdict_t         vrd;
  logic             ack_q, nak_q, wb_q;
  logic [3:0]       bd_pid_q, bd_pid_d;
  logic [MPS_W-1:0] bd_len_q, bd_len_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  usb_ovr_bytecnt #(.MPS_W(MPS_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tok_start  (tok_start),
    .rx_byte_vld(rx_byte_vld),
    .max_pkt    (max_pkt),
    .mem_wr_en  (mem_wr_en),
    .oversize   (oversize),
    .stored_len (stored_len)
  );

  always_comb begin
    lat_d = lat_q;
    if (tok_start)    lat_d = 1'b0;
    else if (lat_ovr) lat_d = 1'b1;
  end
  assign lat_any = lat_q || lat_ovr;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lat_q <= 1'b0;
      pid_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (tok_start) pid_q <= tok_pid;
    end
  end

  usb_ovr_decide u_dec (
    .host_mode(host_mode),
    .iso_xfer (iso_xfer),
    .lat_any  (lat_any),
    .oversize (oversize),
    .tok_pid  (pid_q),
    .vrd      (vrd)
  );

  always_comb begin
    bd_pid_d = bd_pid_q;
    bd_len_d = bd_len_q;
    if (tok_end && vrd.wb) begin
      bd_pid_d = vrd.pid;
      bd_len_d = stored_len;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ack_q    <= 1'b0;
      nak_q    <= 1'b0;
      wb_q     <= 1'b0;
      bd_pid_q <= '0;
      bd_len_q <= '0;
    end else begin
      ack_q    <= tok_end && vrd.ack;
      nak_q    <= tok_end && vrd.nak;
      wb_q     <= tok_end && vrd.wb;
      bd_pid_q <= bd_pid_d;
      bd_len_q <= bd_len_d;
    end
  end

  assign hs_ack = ack_q;
  assign hs_nak = nak_q;
  assign bd_wr  = wb_q;
  assign bd_pid = bd_pid_q;
  assign bd_len = bd_len_q;

  usb_ovr_status u_sts (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .set_dma     (tok_end && vrd.set_dma),
    .set_tok     (tok_end && vrd.wb),
    .clr_wr      (clr_wr),
    .clr_data    (clr_data),
    .err_en_dma  (err_en_dma),
    .int_en_err  (int_en_err),
    .int_en_tok  (int_en_tok),
    .dma_err_sts (dma_err_sts),
    .tok_dne_sts (tok_dne_sts),
    .irq_dma_err (irq_dma_err),
    .irq_tok_done(irq_tok_done)
  );

  AST_HS_EXCL: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(hs_ack && hs_nak)); // R3
  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tok_end && iso_xfer) |=> (!hs_ack && !hs_nak)); // R12
  AST_DEV_LAT_NO_WB: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tok_end && !host_mode && lat_any) |=> !bd_wr); // R8
  AST_LAT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tok_end && lat_any) |=> dma_err_sts); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_i_n)
    bd_wr |-> (bd_len <= max_pkt)); // R5
endmodule

// File: tb/usb_ovr_responder_tb.sv
module usb_ovr_responder_tb;
  localparam int MPS_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 0, iso_xfer = 0, tok_start = 0, tok_end = 0;
  logic rx_byte_vld = 0, lat_ovr = 0;
  logic [3:0] tok_pid = '0;
  logic [MPS_W-1:0] max_pkt = '0;
  logic err_en_dma = 0, int_en_err = 0, int_en_tok = 0, clr_wr = 0;
  logic [1:0] clr_data = '0;
  logic mem_wr_en, hs_ack, hs_nak, bd_wr, dma_err_sts, tok_dne_sts;
  logic irq_dma_err, irq_tok_done;
  logic [3:0] bd_pid;
  logic [MPS_W-1:0] bd_len;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_ovr_responder #(.MPS_W(MPS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .iso_xfer(iso_xfer),
    .tok_start(tok_start), .tok_pid(tok_pid), .tok_end(tok_end),
    .rx_byte_vld(rx_byte_vld), .lat_ovr(lat_ovr), .max_pkt(max_pkt),
    .err_en_dma(err_en_dma), .int_en_err(int_en_err), .int_en_tok(int_en_tok),
    .clr_wr(clr_wr), .clr_data(clr_data), .mem_wr_en(mem_wr_en),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .bd_wr(bd_wr), .bd_pid(bd_pid),
    .bd_len(bd_len), .dma_err_sts(dma_err_sts), .tok_dne_sts(tok_dne_sts),
    .irq_dma_err(irq_dma_err), .irq_tok_done(irq_tok_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One token; clr_mask is written in the tok_end cycle when clr_at_end is set.
  task automatic run_tok(input bit host, input bit iso, input bit lat,
                         input int mp, input int n, input logic [3:0] pid,
                         input bit clr_at_end, input logic [1:0] clr_mask);
    int wr = 0;
    int exp_len;
    bit over;
    host_mode = host; iso_xfer = iso; max_pkt = MPS_W'(mp);
    @(posedge clk); #1 tok_start = 1; tok_pid = pid;
    @(posedge clk); #1 tok_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1; lat_ovr = lat && (i == 0);
      @(negedge clk); if (mem_wr_en) wr++;
      @(posedge clk); #1;
    end
    rx_byte_vld = 0; lat_ovr = lat && (n == 0); tok_end = 1;
    if (clr_at_end) begin clr_wr = 1; clr_data = clr_mask; end
    @(posedge clk); #1 tok_end = 0; lat_ovr = 0; clr_wr = 0; clr_data = '0;
    @(negedge clk);
    over = n > mp;
    exp_len = over ? mp : n;
    chk("R4 writes", wr, exp_len);
    if (lat) begin
      chk("R1/R2/R12 nak", hs_nak, (!host && !iso) ? 1 : 0);
      chk("R2/R12 ack", hs_ack, 0);
      chk("R7/R8 bd_wr", bd_wr, host ? 1 : 0);
      if (host) begin
        chk("R7 pid", bd_pid, 15);
        chk("R5 len", bd_len, exp_len);
      end
      chk("R7/R8 tokdone", tok_dne_sts, host ? 1 : 0);
      chk("R6 dmaerr", dma_err_sts, 1);
    end else begin
      chk("R3/R12 ack", hs_ack, iso ? 0 : 1);
      chk("R3 nak", hs_nak, 0);
      chk("R9 bd_wr", bd_wr, 1);
      chk("R9 pid", bd_pid, pid);
      chk("R5 len", bd_len, exp_len);
      chk("R9 tokdone", tok_dne_sts, 1);
      if (!clr_at_end) chk("R6 dmaerr", dma_err_sts, over ? 1 : 0);
    end
  endtask

  task automatic clear_all();
    @(posedge clk); #1 clr_wr = 1; clr_data = 2'b11;
    @(posedge clk); #1 clr_wr = 0; clr_data = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mps [4] = '{0, 1, 7, 15};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6 reset dmaerr", dma_err_sts, 0);
    chk("R9 reset tokdone", tok_dne_sts, 0);
    chk("R3 reset ack", hs_ack, 0);
    chk("R1 reset nak", hs_nak, 0);
    chk("R9 reset bd_wr", bd_wr, 0);

    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++)
          for (int m = 0; m < 4; m++)
            for (int k = 0; k < 5; k++) begin
              int mp = mps[m];
              int n;
              case (k)
                0: n = 0;
                1: n = (mp > 0) ? mp - 1 : 0;
                2: n = mp;
                3: n = mp + 1;
                default: n = mp + 3;
              endcase
              run_tok(h[0], s[0], l[0], mp, n, (h != 0) ? 4'h9 : 4'h1, 0, 2'b00);
              clear_all();
              @(negedge clk);
              chk("R11 cleared dma", dma_err_sts, 0);
              chk("R11 cleared tok", tok_dne_sts, 0);
            end

    // R10: enable gating with both status bits set (device, oversized)
    run_tok(0, 0, 0, 3, 6, 4'h1, 0, 2'b00);
    for (int e = 0; e < 8; e++) begin
      @(posedge clk); #1 err_en_dma = e[0]; int_en_err = e[1]; int_en_tok = e[2];
      @(negedge clk);
      chk("R10 irq_err", irq_dma_err, (e[0] && e[1]) ? 1 : 0);
      chk("R10 irq_tok", irq_tok_done, e[2] ? 1 : 0);
    end
    // R11: writing 0 bits leaves status; only bit 1 cleared
    @(posedge clk); #1 clr_wr = 1; clr_data = 2'b10;
    @(posedge clk); #1 clr_wr = 0; clr_data = 2'b00;
    @(negedge clk);
    chk("R11 keep dma", dma_err_sts, 1);
    chk("R11 clear tok", tok_dne_sts, 0);
    chk("R10 irq_tok off", irq_tok_done, 0);
    chk("R10 irq_err on", irq_dma_err, 1);
    clear_all();
    @(negedge clk);
    chk("R10 irq_err off", irq_dma_err, 0);
    err_en_dma = 0; int_en_err = 0; int_en_tok = 0;

    // R11: clear in the same cycle as a new error: set wins
    run_tok(1, 0, 0, 2, 5, 4'h9, 1, 2'b11);
    chk("R11 set wins dma", dma_err_sts, 1);
    chk("R11 set wins tok", tok_dne_sts, 1);
    clear_all();
    // R6 latency in device mode with both causes present
    run_tok(0, 0, 1, 2, 5, 4'h1, 0, 2'b00);
    clear_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule